// File: doc/BRIEF.md
# Self-Routing Cube Interconnect with Stage Partitioning

This block moves one word per lane from P source lanes to P destination lanes through log2(P) columns of two-by-two switch boxes. Each word has a valid bit and a destination lane number. Every box sets itself from one bit of the tag of the words that reach it, so no central controller has to compute switch settings. The network is combinational from input to output, with a single register bank at the output. A result therefore appears exactly one clock after its inputs are presented.

The network is built for lockstep processor arrays. In those arrays every lane sends to the lane a fixed distance away, wrapping modulo P. Any such uniform rotation passes through the network in one pass with no box conflict. A per-stage force vector holds whole stages in the straight setting. This cuts the lanes into independent power-of-two groups, and each group behaves as a smaller cube. Two diagnostics are reported. One flag shows that two words contended for the same box output. The other shows that a word was addressed outside the group its lane belongs to.

Top module: `cube_net`

## Requirements
- R1: While `rst_n` is low, `out_valid` is all zero, `out_data` is all zero, and `route_conflict` and `tag_error` are 0.
- R2: Outputs change only on a rising clock edge. The values presented before an edge show up at the outputs after that edge and hold until the next edge.
- R3: The stages act from tag bit LG-1 down to bit 0. At the stage for bit s, a box pairs the two lanes whose numbers differ only in bit s. A word whose tag bit s is 0 leaves on the lane with bit s clear, and a word whose tag bit s is 1 leaves on the lane with bit s set.
- R4: If no conflict and no tag error occurs, each valid word arrives at the lane equal to its tag (3 bits for P=8) with its data unchanged, and that lane's `out_valid` bit is 1.
- R5: For every shift x from 0 to P-1, tags of (k+x) mod P on all lanes give `route_conflict` = 0, and every word is delivered as in R4.
- R6: The number of set bits in `out_valid` equals the number of valid inputs of the previous cycle. No word is lost or duplicated.
- R7: A box conflict occurs when both of its inputs are valid and ask for the same output. Such a conflict sets `route_conflict`. The word on the box's bit-s-clear input gets the output it asked for, and the other word takes the remaining output.
- R8: Setting `stage_force[s]` = 1 holds every box of stage s straight. With the top k stages forced, the lanes form independent groups of P/2^k consecutive lanes. A rotation inside each group is delivered with no conflict.
- R9: A valid word whose tag bit s differs from its source lane bit s at a forced stage s sets `tag_error`. That word arrives at the lane given by its tag with bit s taken from its source lane.
- R10: Inputs with `in_valid` = 0 affect nothing. Their tags and data never cause a conflict, a tag error or a delivered word. A single valid word with no forced stage never conflicts.
- R11: Every output lane whose `out_valid` bit is 0 shows all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | P | Word present on each source lane |
| in_tag | input | P*LG | Destination lane of each word, lane k at bits [k*LG +: LG] |
| in_data | input | P*W | Payload of each word, lane k at bits [k*W +: W] |
| stage_force | input | LG | Bit s holds all boxes of stage s straight |
| out_valid | output | P | Word delivered on each destination lane |
| out_data | output | P*W | Delivered payloads, zero where not valid |
| route_conflict | output | 1 | Some box saw both inputs asking for the same output |
| tag_error | output | 1 | Some word was addressed outside its partition |

## Verification
The bench runs every rotation amount, including zero and P-1. A wrong pairing rule or a wrong stage order would show up on these as conflicts or as words delivered to the wrong lane. It runs rotations inside one-stage and two-stage partitions, where a stage that ignores its force bit would send words between groups. It also runs a sparse rotation with garbage on the invalid lanes, which exposes any design that lets invalid inputs set boxes or leak data. One hand-worked contention case pins down the priority rule and where the losing word lands. A single out-of-group word checks both the error flag and its fallback lane.

// File: rtl/cube_pkg.sv
`timescale 1ns/1ps
package cube_pkg;

    typedef enum logic {
        BOX_STRAIGHT = 1'b0,
        BOX_EXCHANGE = 1'b1
    } box_set_e;

    // lane number of the bit-s-clear input of box b in the stage for bit s
    function automatic int upper_line(input int b, input int s);
        return ((b >> s) << (s + 1)) | (b & ((1 << s) - 1));
    endfunction

endpackage

// File: rtl/cube_box.sv
`timescale 1ns/1ps
module cube_box
    import cube_pkg::*;
#(
    parameter int W   = 8,
    parameter int LG  = 3,
    parameter int S   = 0,
    localparam int WRD = 1 + LG + W
) (
    input  logic [WRD-1:0] up_i,
    input  logic [WRD-1:0] lo_i,
    input  logic           force_i,
    output logic [WRD-1:0] up_o,
    output logic [WRD-1:0] lo_o,
    output logic           conflict_o,
    output logic           tag_err_o
);
    localparam int VB = W + LG;   // valid bit position
    localparam int TB = W + S;    // tag bit steered by this stage

    logic     up_v, lo_v, up_b, lo_b;
    box_set_e set_d;

    always_comb begin
        up_v = up_i[VB];
        lo_v = lo_i[VB];
        up_b = up_i[TB];
        lo_b = lo_i[TB];

        if (force_i)
            set_d = BOX_STRAIGHT;
        else if (up_v)
            set_d = up_b ? BOX_EXCHANGE : BOX_STRAIGHT;
        else if (lo_v)
            set_d = lo_b ? BOX_STRAIGHT : BOX_EXCHANGE;
        else
            set_d = BOX_STRAIGHT;

        if (set_d == BOX_EXCHANGE) begin
            up_o = lo_i;
            lo_o = up_i;
        end else begin
            up_o = up_i;
            lo_o = lo_i;
        end

        conflict_o = !force_i && up_v && lo_v && (up_b == lo_b);
        tag_err_o  = force_i && ((up_v && up_b) || (lo_v && !lo_b));
    end
endmodule

// File: rtl/cube_stage.sv
`timescale 1ns/1ps
module cube_stage
    import cube_pkg::*;
#(
    parameter int P  = 8,
    parameter int W  = 8,
    parameter int S  = 0,
    localparam int LG   = $clog2(P),
    localparam int WRD  = 1 + LG + W,
    localparam int HALF = P / 2
) (
    input  logic [P*WRD-1:0] bus_i,
    input  logic             force_i,
    output logic [P*WRD-1:0] bus_o,
    output logic [HALF-1:0]  conflict_o,
    output logic [HALF-1:0]  tag_err_o
);
    for (genvar b = 0; b < HALF; b++) begin : g_box
        localparam int UP = upper_line(b, S);
        localparam int LO = UP + (1 << S);

        cube_box #(.W(W), .LG(LG), .S(S)) u_box (
            .up_i       (bus_i[UP*WRD +: WRD]),
            .lo_i       (bus_i[LO*WRD +: WRD]),
            .force_i    (force_i),
            .up_o       (bus_o[UP*WRD +: WRD]),
            .lo_o       (bus_o[LO*WRD +: WRD]),
            .conflict_o (conflict_o[b]),
            .tag_err_o  (tag_err_o[b])
        );
    end
endmodule

// File: rtl/cube_net.sv
`timescale 1ns/1ps
module cube_net
    import cube_pkg::*;
#(
    parameter int P = 8,
    parameter int W = 8,
    localparam int LG   = $clog2(P),
    localparam int WRD  = 1 + LG + W,
    localparam int HALF = P / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [P-1:0]    in_valid,
    input  logic [P*LG-1:0] in_tag,
    input  logic [P*W-1:0]  in_data,
    input  logic [LG-1:0]   stage_force,
    output logic [P-1:0]    out_valid,
    output logic [P*W-1:0]  out_data,
    output logic            route_conflict,
    output logic            tag_error
);
    typedef struct packed {
        logic [P-1:0]   vld;
        logic [P*W-1:0] dat;
        logic           cfl;
        logic           terr;
    } out_state_t;

    logic [P*WRD-1:0]   lvl [0:LG];
    logic [LG*HALF-1:0] cfl_bits;
    logic [LG*HALF-1:0] terr_bits;
    out_state_t         st_d, st_q;

    // pack each lane as {valid, tag, data}
    always_comb begin
        for (int k = 0; k < P; k++) begin
            lvl[0][k*WRD +: WRD] = {in_valid[k], in_tag[k*LG +: LG], in_data[k*W +: W]};
        end
    end

    // column j steers tag bit LG-1-j
    for (genvar j = 0; j < LG; j++) begin : g_stage
        localparam int SB = LG - 1 - j;
        cube_stage #(.P(P), .W(W), .S(SB)) u_stage (
            .bus_i      (lvl[j]),
            .force_i    (stage_force[SB]),
            .bus_o      (lvl[j+1]),
            .conflict_o (cfl_bits[j*HALF +: HALF]),
            .tag_err_o  (terr_bits[j*HALF +: HALF])
        );
    end

    always_comb begin
        st_d = '0;
        for (int k = 0; k < P; k++) begin
            st_d.vld[k] = lvl[LG][k*WRD + W + LG];
            st_d.dat[k*W +: W] = st_d.vld[k] ? lvl[LG][k*WRD +: W] : '0;
        end
        st_d.cfl  = |cfl_bits;
        st_d.terr = |terr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid      = st_q.vld;
    assign out_data       = st_q.dat;
    assign route_conflict = st_q.cfl;
    assign tag_error      = st_q.terr;
endmodule

// File: rtl/cube_net_chk.sv
`timescale 1ns/1ps
module cube_net_chk #(
    parameter int P = 8,
    parameter int W = 8,
    localparam int LG = $clog2(P)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [P-1:0]    in_valid,
    input logic [P*LG-1:0] in_tag,
    input logic [LG-1:0]   stage_force,
    input logic [P-1:0]    out_valid,
    input logic            route_conflict,
    input logic            tag_error
);
    function automatic logic [P-1:0] lone_dest(input logic [P-1:0] v, input logic [P*LG-1:0] t);
        logic [P-1:0] r;
        r = '0;
        for (int k = 0; k < P; k++) begin
            if (v[k]) r = P'(1) << t[k*LG +: LG];
        end
        return r;
    endfunction

    // R6
    word_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(out_valid) == $countones($past(in_valid)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) == '0) |-> (!route_conflict && out_valid == '0));

    // R3
    lone_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $countones($past(in_valid)) == 1 && $past(stage_force) == '0)
        |-> (!route_conflict && out_valid == $past(lone_dest(in_valid, in_tag))));

    // R9
    terr_needs_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && tag_error) |-> $past(stage_force) != '0);
endmodule

bind cube_net cube_net_chk #(.P(P), .W(W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_tag         (in_tag),
    .stage_force    (stage_force),
    .out_valid      (out_valid),
    .route_conflict (route_conflict),
    .tag_error      (tag_error)
);

// File: tb/cube_net_bench.sv
`timescale 1ns/1ps
module cube_net_bench;
    localparam int P  = 8;
    localparam int W  = 8;
    localparam int LG = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [P-1:0]    in_valid;
    logic [P*LG-1:0] in_tag;
    logic [P*W-1:0]  in_data;
    logic [LG-1:0]   stage_force;
    logic [P-1:0]    out_valid;
    logic [P*W-1:0]  out_data;
    logic            route_conflict;
    logic            tag_error;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [LG-1:0] tg [P];
    logic [W-1:0]  dt [P];

    always #4 clk = ~clk;

    cube_net #(.P(P), .W(W)) u_cube_net (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_data(in_data), .stage_force(stage_force), .out_valid(out_valid),
        .out_data(out_data), .route_conflict(route_conflict), .tag_error(tag_error)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [P-1:0] v, input logic [LG-1:0] f);
        in_valid    = v;
        stage_force = f;
        for (int k = 0; k < P; k++) begin
            in_tag[k*LG +: LG] = tg[k];
            in_data[k*W +: W]  = dt[k];
        end
    endtask

    // reference: word lands on its tag, forced bits kept from the source lane
    task automatic run_vec(input string req, input logic [P-1:0] v, input logic [LG-1:0] f);
        logic [P-1:0]   ev;
        logic [P*W-1:0] ed;
        logic           eterr;
        ev = '0; ed = '0; eterr = 1'b0;
        for (int k = 0; k < P; k++) begin
            if (v[k]) begin
                int dst;
                dst = int'((tg[k] & ~f) | (LG'(k) & f));
                ev[dst] = 1'b1;
                ed[dst*W +: W] = dt[k];
                if (((tg[k] ^ LG'(k)) & f) != '0) eterr = 1'b1;
            end
        end
        @(negedge clk);
        drive(v, f);
        @(posedge clk);
        @(negedge clk);
        check({req, " valid"}, 64'(out_valid), 64'(ev));
        check({req, " data"}, 64'(out_data), 64'(ed));
        check({req, " conflict"}, 64'(route_conflict), 64'(0));
        check({req, " tag_error"}, 64'(tag_error), 64'(eterr));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        for (int k = 0; k < P; k++) begin tg[k] = '0; dt[k] = '0; end
        drive('0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 valid", 64'(out_valid), 64'(0));
        check("R1 data", 64'(out_data), 64'(0));
        check("R1 flags", 64'({route_conflict, tag_error}), 64'(0));
        rst_n = 1'b1;

        // R5 / R4: every rotation amount
        for (int x = 0; x < P; x++) begin
            for (int k = 0; k < P; k++) begin
                tg[k] = LG'((k + x) % P);
                dt[k] = W'(8'h30 + k * 5 + x);
            end
            run_vec($sformatf("R5 shift %0d", x), '1, '0);
        end

        // R3: pairwise swap, exchange only at bit 0 stage
        for (int k = 0; k < P; k++) begin tg[k] = LG'(k ^ 1); dt[k] = W'(8'hA0 + k); end
        run_vec("R3 swap", '1, '0);

        // R2: outputs hold until next edge
        @(negedge clk);
        drive('0, '0);
        #2;
        check("R2 hold", 64'(out_valid), 64'(8'hFF));
        @(posedge clk);
        @(negedge clk);
        check("R2 update", 64'(out_valid), 64'(0));

        // R10 / R11: sparse rotation, garbage on invalid lanes
        for (int k = 0; k < P; k++) begin tg[k] = LG'((k + 5) % P); dt[k] = W'(8'h11 * k + 1); end
        tg[1] = 3'd5; tg[6] = 3'd4;
        run_vec("R10 R11 sparse", 8'b1011_0101, '0);

        // R8: top stage forced, rotation inside each half
        for (int x = 0; x < 4; x++) begin
            for (int k = 0; k < P; k++) begin
                int y;
                y = (k < 4) ? x : (3 - x);
                tg[k] = LG'((k & 4) | ((k + y) & 3));
                dt[k] = W'(8'h50 + k + 16 * x);
            end
            run_vec($sformatf("R8 halves %0d", x), '1, 3'b100);
        end
        // R8: two stages forced, swap inside pairs
        for (int k = 0; k < P; k++) begin tg[k] = LG'(k ^ 1); dt[k] = W'(8'hC0 + k); end
        run_vec("R8 pairs", '1, 3'b110);

        // R9: lane 1 addressed to lane 6 across a forced top stage -> lands on 2
        for (int k = 0; k < P; k++) begin tg[k] = '0; dt[k] = '0; end
        tg[1] = 3'd6; dt[1] = 8'h9C;
        run_vec("R9 escape", 8'b0000_0010, 3'b100);

        // R7: lanes 0 (tag 5) and 4 (tag 6) contend at bit-2 box
        tg[0] = 3'd5; dt[0] = 8'h3E;
        tg[4] = 3'd6; dt[4] = 8'h7D;
        @(negedge clk);
        drive(8'b0001_0001, '0);
        @(posedge clk);
        @(negedge clk);
        check("R7 conflict", 64'(route_conflict), 64'(1));
        check("R7 valid", 64'(out_valid), 64'(8'b0010_0100));
        check("R7 winner lane5", 64'(out_data[5*W +: W]), 64'(8'h3E));
        check("R7 loser lane2", 64'(out_data[2*W +: W]), 64'(8'h7D));
        check("R6 count", 64'($countones(out_valid)), 64'(2));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule